// File: doc/BRIEF.md
# Audio DAC Power Sequencing Controller

This controller steers an audio converter's analog output stage from reset, through a pop-free power-up, into normal output and back to a discharged standby. It decides once after each reset whether a control port is present. The control port counts as present if a register-write strobe arrives before a speed-dependent number of sample-clock strobes has elapsed. Without a control port the controller runs stand-alone and powers up by itself.

Power-up with pop suppression first holds the outputs clamped to ground for a fixed number of sample periods. It then enables a ramp toward the quiescent level for a parameterised number of sample periods, and only then connects the output buffers. With pop suppression off, a fixed clock-cycle delay replaces the clamp and ramp phases. On power-down the buffers are dropped and a discharge sink is enabled. The sink is held for a minimum number of clock cycles, and a power-up request made during that time waits until the hold has run out. The analog ramp, the capacitor discharge and the serial port protocol are modelled only as counts and strobes.

Top module: `dac_pwr_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `clamp_gnd`=1 and `ramp_en`, `buf_connect`, `sink_en`, `vq_ready` and `ctrl_mode` all 0.
- R2: After reset release, the outputs stay in the low-power pattern (`clamp_gnd`=1, `vq_ready`=0) while the port decision is pending, and also while `ctrl_mode`=1 and `pdn_bit`=1.
- R3: The claim window length is WIN_BASE sample strobes scaled by `speed_sel`: 00 gives x1, 01 gives x2, 10 or 11 gives x4. If `wr_stb` is seen before the strobe that ends the window, or in the same cycle as that strobe, `ctrl_mode` becomes 1 the next cycle. It then stays 1 until reset.
- R4: If the window's last strobe passes with no write, hardware mode is latched. `ctrl_mode` stays 0, later `wr_stb` pulses are ignored, `pdn_bit` is ignored, and power-up starts on its own.
- R5: With `ctrl_mode`=1, a 0 on `pdn_bit` starts power-up from standby.
- R6: With `pop_en`=1, power-up keeps `clamp_gnd`=1 for exactly CLAMP_SAMPLES sample strobes. It then raises `ramp_en`, with `clamp_gnd`=0, for exactly RAMP_SAMPLES sample strobes.
- R7: When the ramp ends, `buf_connect` and `vq_ready` go to 1 together.
- R8: With `pop_en`=0, power-up keeps `clamp_gnd`=1 for exactly FIXED_CYCLES clock cycles, never raises `ramp_en`, and then raises `vq_ready`.
- R9: In control mode, `pdn_bit`=1 during any power-up phase or normal output gives `buf_connect`=0, `vq_ready`=0 and `sink_en`=1 in the next cycle.
- R10: `sink_en` stays 1 for at least DISCH_CYCLES clock cycles. A `pdn_bit` cleared earlier is held pending, and power-up begins in the cycle after the last hold cycle. If `pdn_bit` is still 1 then, the sink stays on until it clears.
- R11: Reset taken at any point, including mid-ramp, returns the controller to the R1 state in the next cycle.
- R12: At most one of `clamp_gnd`, `ramp_en`, `buf_connect` and `sink_en` is 1 in any cycle, and `vq_ready` is 1 only with `buf_connect`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lrck_tick | input | 1 | One-cycle strobe per sample period |
| speed_sel | input | 2 | Sample-rate range: 00 single, 01 double, 1x quad |
| wr_stb | input | 1 | Register-write strobe from the control port |
| pdn_bit | input | 1 | Power-down register bit, 1 = stay down |
| pop_en | input | 1 | 1 = clamp-and-ramp power-up, 0 = fixed delay |
| clamp_gnd | output | 1 | Hold analog outputs at ground |
| ramp_en | output | 1 | Ramp outputs toward quiescent level |
| buf_connect | output | 1 | Output buffers driving the pins |
| sink_en | output | 1 | Slow discharge current sink on |
| vq_ready | output | 1 | Outputs at quiescent level, audio live |
| ctrl_mode | output | 1 | 1 = control port claimed in time |

## Verification
The claim window is probed at its exact edge for each speed code. This includes a write in the same cycle as the closing strobe. A window that is off by one or that ignores the speed scaling would flip the mode flag. The clamp and ramp strobe counts, the fixed delay and the discharge hold are measured exactly, so an early or late transition shows up as a count error. A power-down pulse that is cleared during discharge must not shorten the hold, and a long-held power-down must keep the sink on. Reset taken mid-ramp, and power-down or write pulses in hardware mode, would expose a controller that leaks state or obeys ignored inputs.

// File: rtl/dac_pwr_pkg.sv
`timescale 1ns/1ps
// Shared types for the DAC power sequencing controller.
// Assumes speed codes 00/01/1x map to window multipliers 1/2/4.
package dac_pwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLAMP = 3'd1,
        ST_RAMP  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_RUN   = 3'd4,
        ST_DISCH = 3'd5
    } seq_state_t;

    // Left shift applied to the base claim window for a speed code.
    function automatic logic [1:0] win_shift(input logic [1:0] spd);
        case (spd)
            2'b00:   win_shift = 2'd0;
            2'b01:   win_shift = 2'd1;
            default: win_shift = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/dac_mode_claim.sv
`timescale 1ns/1ps
// Decides once per reset whether a control port is present.
// Counts sample strobes; a write before the window closes claims control
// mode, otherwise hardware mode is latched. Both flags hold until reset.
// Assumes wr_stb and lrck_tick are single-cycle strobes in the clk domain.
module dac_mode_claim
    import dac_pwr_pkg::*;
#(
    parameter int WIN_BASE = 192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lrck_tick,
    input  logic [1:0] speed_sel,
    input  logic       wr_stb,
    output logic       ctrl_q,
    output logic       hw_q
);

    localparam int WIN_MAX = WIN_BASE * 4;
    localparam int CW      = $clog2(WIN_MAX + 1);

    logic [CW-1:0] tick_cnt;
    logic [CW-1:0] win_last;

    // Index of the strobe that closes the window for the current speed.
    always_comb begin
        win_last = (CW'(WIN_BASE) << win_shift(speed_sel)) - CW'(1);
    end

    // Window counter and the two sticky decision flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            ctrl_q   <= 1'b0;
            hw_q     <= 1'b0;
        end else if (!ctrl_q && !hw_q) begin
            if (wr_stb) begin
                ctrl_q <= 1'b1;
            end else if (lrck_tick) begin
                if (tick_cnt >= win_last) begin
                    hw_q <= 1'b1;
                end else begin
                    tick_cnt <= tick_cnt + CW'(1);
                end
            end
        end
    end

    // R4
    claim_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_q && hw_q));

    // R3
    claim_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q |=> ctrl_q);

    // R4
    hw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_q |=> (hw_q && !ctrl_q));

endmodule

// File: rtl/dac_seq_fsm.sv
`timescale 1ns/1ps
// Power sequencing state machine: standby, clamp, ramp or fixed wait,
// normal output, and discharge with a minimum hold.
// Clamp and ramp lengths count sample strobes; the fixed wait and the
// discharge hold count clock cycles. up_req and down_req come from the
// mode decision and are never both high.
module dac_seq_fsm
    import dac_pwr_pkg::*;
#(
    parameter int CLAMP_SAMPLES = 192,
    parameter int RAMP_SAMPLES  = 2048,
    parameter int FIXED_CYCLES  = 26000000,
    parameter int DISCH_CYCLES  = 40000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lrck_tick,
    input  logic       up_req,
    input  logic       down_req,
    input  logic       pop_en,
    output seq_state_t state_q
);

    localparam int SMAX = (CLAMP_SAMPLES > RAMP_SAMPLES) ? CLAMP_SAMPLES : RAMP_SAMPLES;
    localparam int CMAX = (FIXED_CYCLES > DISCH_CYCLES) ? FIXED_CYCLES : DISCH_CYCLES;
    localparam int SW   = $clog2(SMAX + 1);
    localparam int CCW  = $clog2(CMAX + 1);
    localparam logic [SW-1:0]  CLAMP_LAST = SW'(CLAMP_SAMPLES - 1);
    localparam logic [SW-1:0]  RAMP_LAST  = SW'(RAMP_SAMPLES - 1);
    localparam logic [CCW-1:0] FIXED_LAST = CCW'(FIXED_CYCLES - 1);
    localparam logic [CCW-1:0] DISCH_LAST = CCW'(DISCH_CYCLES - 1);

    seq_state_t     state_d;
    logic [SW-1:0]  samp_q, samp_d;
    logic [CCW-1:0] cyc_q, cyc_d;
    logic           disch_done;
    seq_state_t     up_target;

    // Hold is over once the cycle counter sits on its last value.
    assign disch_done = (cyc_q == DISCH_LAST);
    // First power-up phase depends on the pop-suppression choice.
    assign up_target  = pop_en ? ST_CLAMP : ST_WAIT;

    // Next-state and counter update for every phase.
    always_comb begin
        state_d = state_q;
        samp_d  = samp_q;
        cyc_d   = cyc_q;
        unique case (state_q)
            ST_IDLE: begin
                if (up_req) begin
                    state_d = up_target;
                    samp_d  = '0;
                    cyc_d   = '0;
                end
            end
            ST_CLAMP, ST_RAMP, ST_WAIT, ST_RUN: begin
                if (down_req) begin
                    state_d = ST_DISCH;
                    cyc_d   = '0;
                end else if (state_q == ST_CLAMP) begin
                    if (lrck_tick) begin
                        if (samp_q == CLAMP_LAST) begin
                            state_d = ST_RAMP;
                            samp_d  = '0;
                        end else begin
                            samp_d = samp_q + SW'(1);
                        end
                    end
                end else if (state_q == ST_RAMP) begin
                    if (lrck_tick) begin
                        if (samp_q == RAMP_LAST) begin
                            state_d = ST_RUN;
                            samp_d  = '0;
                        end else begin
                            samp_d = samp_q + SW'(1);
                        end
                    end
                end else if (state_q == ST_WAIT) begin
                    if (cyc_q == FIXED_LAST) begin
                        state_d = ST_RUN;
                        cyc_d   = '0;
                    end else begin
                        cyc_d = cyc_q + CCW'(1);
                    end
                end
            end
            ST_DISCH: begin
                if (!disch_done) begin
                    cyc_d = cyc_q + CCW'(1);
                end else if (up_req) begin
                    state_d = up_target;
                    samp_d  = '0;
                    cyc_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            samp_q  <= '0;
            cyc_q   <= '0;
        end else begin
            state_q <= state_d;
            samp_q  <= samp_d;
            cyc_q   <= cyc_d;
        end
    end

    // R10
    disch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISCH && !disch_done) |=> (state_q == ST_DISCH));

    // R6
    ramp_after_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP && $past(state_q) != ST_RAMP) |-> ($past(state_q) == ST_CLAMP));

    // R9
    down_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (down_req && state_q inside {ST_CLAMP, ST_RAMP, ST_WAIT, ST_RUN}) |=> (state_q == ST_DISCH));

    // R7
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> ($past(state_q) inside {ST_RAMP, ST_WAIT}));

endmodule

// File: rtl/dac_out_decode.sv
`timescale 1ns/1ps
// Maps the sequencer state onto the analog control outputs.
// Purely combinational; assumes one state per cycle from dac_seq_fsm.
module dac_out_decode
    import dac_pwr_pkg::*;
(
    input  seq_state_t state,
    output logic       clamp_gnd,
    output logic       ramp_en,
    output logic       buf_connect,
    output logic       sink_en,
    output logic       vq_ready
);

    // One control pattern per sequencer state.
    always_comb begin
        clamp_gnd   = 1'b0;
        ramp_en     = 1'b0;
        buf_connect = 1'b0;
        sink_en     = 1'b0;
        vq_ready    = 1'b0;
        unique case (state)
            ST_IDLE, ST_CLAMP, ST_WAIT: clamp_gnd = 1'b1;
            ST_RAMP:  ramp_en = 1'b1;
            ST_RUN: begin
                buf_connect = 1'b1;
                vq_ready    = 1'b1;
            end
            ST_DISCH: sink_en = 1'b1;
            default:  clamp_gnd = 1'b1;
        endcase
    end

endmodule

// File: rtl/dac_pwr_seq.sv
`timescale 1ns/1ps
// Top of the DAC power sequencing controller.
// Combines the control-port claim window, the sequencer and the output
// decode. In hardware mode the power-down bit is treated as 0.
module dac_pwr_seq
    import dac_pwr_pkg::*;
#(
    parameter int WIN_BASE      = 192,
    parameter int CLAMP_SAMPLES = 192,
    parameter int RAMP_SAMPLES  = 2048,
    parameter int FIXED_CYCLES  = 26000000,
    parameter int DISCH_CYCLES  = 40000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lrck_tick,
    input  logic [1:0] speed_sel,
    input  logic       wr_stb,
    input  logic       pdn_bit,
    input  logic       pop_en,
    output logic       clamp_gnd,
    output logic       ramp_en,
    output logic       buf_connect,
    output logic       sink_en,
    output logic       vq_ready,
    output logic       ctrl_mode
);

    logic       ctrl_q, hw_q;
    logic       decided, pdn_eff, up_req, down_req;
    seq_state_t state;

    // Effective power-down request once the mode is known.
    assign decided   = ctrl_q | hw_q;
    assign pdn_eff   = ctrl_q & pdn_bit;
    assign up_req    = decided & ~pdn_eff;
    assign down_req  = pdn_eff;
    assign ctrl_mode = ctrl_q;

    dac_mode_claim #(
        .WIN_BASE (WIN_BASE)
    ) u_claim (
        .clk       (clk),
        .rst_n     (rst_n),
        .lrck_tick (lrck_tick),
        .speed_sel (speed_sel),
        .wr_stb    (wr_stb),
        .ctrl_q    (ctrl_q),
        .hw_q      (hw_q)
    );

    dac_seq_fsm #(
        .CLAMP_SAMPLES (CLAMP_SAMPLES),
        .RAMP_SAMPLES  (RAMP_SAMPLES),
        .FIXED_CYCLES  (FIXED_CYCLES),
        .DISCH_CYCLES  (DISCH_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lrck_tick (lrck_tick),
        .up_req    (up_req),
        .down_req  (down_req),
        .pop_en    (pop_en),
        .state_q   (state)
    );

    dac_out_decode u_dec (
        .state       (state),
        .clamp_gnd   (clamp_gnd),
        .ramp_en     (ramp_en),
        .buf_connect (buf_connect),
        .sink_en     (sink_en),
        .vq_ready    (vq_ready)
    );

    // R12
    out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clamp_gnd, ramp_en, buf_connect, sink_en}));

    // R4
    hw_no_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_q && !sink_en) |=> !sink_en);

endmodule

// File: tb/dac_pwr_seq_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed window edges and phase lengths, plus
// seeded random rounds checked against bench-side rules.
module dac_pwr_seq_test;

    localparam int WB = 16;
    localparam int CS = 12;
    localparam int RS = 20;
    localparam int FC = 50;
    localparam int DC = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lrck_tick = 1'b0;
    logic [1:0] speed_sel = 2'b00;
    logic       wr_stb = 1'b0;
    logic       pdn_bit = 1'b1;
    logic       pop_en = 1'b1;
    logic       clamp_gnd, ramp_en, buf_connect, sink_en, vq_ready, ctrl_mode;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    dac_pwr_seq #(
        .WIN_BASE (WB), .CLAMP_SAMPLES (CS), .RAMP_SAMPLES (RS),
        .FIXED_CYCLES (FC), .DISCH_CYCLES (DC)
    ) uut (
        .clk (clk), .rst_n (rst_n), .lrck_tick (lrck_tick), .speed_sel (speed_sel),
        .wr_stb (wr_stb), .pdn_bit (pdn_bit), .pop_en (pop_en),
        .clamp_gnd (clamp_gnd), .ramp_en (ramp_en), .buf_connect (buf_connect),
        .sink_en (sink_en), .vq_ready (vq_ready), .ctrl_mode (ctrl_mode)
    );

    function automatic int win_len(input logic [1:0] s);
        return (s == 2'b00) ? WB : (s == 2'b01) ? 2 * WB : 4 * WB;
    endfunction

    function automatic bit rnd_tick();
        return ($urandom_range(2, 0) == 0);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(negedge clk);
        rst_n = 1'b0; lrck_tick = 1'b0; wr_stb = 1'b0; pdn_bit = 1'b1; speed_sel = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Claim attempt: n strobes, then a write (with a strobe if same=1).
    task automatic window_try(input logic [1:0] s, input int n, input bit same);
        bit exp;
        do_reset(s);
        pop_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            lrck_tick = 1'b1; @(negedge clk);
            lrck_tick = 1'b0; @(negedge clk);
        end
        wr_stb = 1'b1; lrck_tick = same; @(negedge clk);
        wr_stb = 1'b0; lrck_tick = 1'b0; @(negedge clk);
        exp = (n < win_len(s));
        if (exp) chk(ctrl_mode == 1'b1, "R3 claim inside window", int'(ctrl_mode), 1);
        else     chk(ctrl_mode == 1'b0, "R4 write after window ignored", int'(ctrl_mode), 0);
    endtask

    // Starting at the first clamp cycle, count strobes in clamp and in ramp.
    task automatic measure_pop(output int ct, output int rt, output int errs);
        bit t;
        int g;
        ct = 0; rt = 0; errs = 0; g = 0;
        while (!ramp_en && g < 4000) begin
            if (!clamp_gnd) errs++;
            t = rnd_tick(); lrck_tick = t; ct += int'(t); g++;
            @(negedge clk);
        end
        while (ramp_en && g < 8000) begin
            if (clamp_gnd) errs++;
            t = rnd_tick(); lrck_tick = t; rt += int'(t); g++;
            @(negedge clk);
        end
        lrck_tick = 1'b0;
    endtask

    task automatic run_until_vq(output int cyc);
        cyc = 0;
        while (!vq_ready && cyc < 8000) begin
            lrck_tick = rnd_tick(); cyc++;
            @(negedge clk);
        end
        lrck_tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ct, rt, errs, cnt, run, viol;
        bit claim;
        logic [1:0] s;
        void'($urandom(32'd1234));

        // R1 reset state
        repeat (2) @(negedge clk);
        chk(clamp_gnd && !ramp_en && !buf_connect && !sink_en && !vq_ready && !ctrl_mode,
            "R1 reset outputs", {clamp_gnd, ramp_en, buf_connect, sink_en, vq_ready, ctrl_mode}, 6'b100000);

        // R3 / R4 window edges for each speed code
        window_try(2'b00, WB - 1, 1'b0);
        window_try(2'b00, WB - 1, 1'b1);
        window_try(2'b00, WB,     1'b0);
        window_try(2'b01, 2 * WB - 1, 1'b0);
        window_try(2'b01, 2 * WB,     1'b0);
        window_try(2'b10, 4 * WB - 1, 1'b0);
        window_try(2'b10, 4 * WB,     1'b0);
        window_try(2'b11, 4 * WB - 1, 1'b1);

        // R2 claimed with pdn_bit=1 stays in standby
        window_try(2'b00, 3, 1'b0);
        repeat (40) begin lrck_tick = rnd_tick(); @(negedge clk); end
        lrck_tick = 1'b0;
        chk(clamp_gnd && !vq_ready && !ramp_en, "R2 standby with power-down set",
            {clamp_gnd, vq_ready}, 2'b10);

        // R5 / R6 / R7 pop-suppressed power-up
        pop_en = 1'b1; pdn_bit = 1'b0;
        @(negedge clk);
        measure_pop(ct, rt, errs);
        chk(ct == CS, "R6 clamp strobe count", ct, CS);
        chk(rt == RS, "R6 ramp strobe count", rt, RS);
        chk(errs == 0, "R6 clamp/ramp overlap", errs, 0);
        chk(vq_ready && buf_connect, "R7 output live after ramp", {vq_ready, buf_connect}, 2'b11);

        // R9 / R10 short power-down pulse: hold not shortened, up pending
        pdn_bit = 1'b1; @(negedge clk);
        pdn_bit = 1'b0;
        chk(sink_en && !buf_connect && !vq_ready, "R9 power-down entry",
            {sink_en, buf_connect, vq_ready}, 3'b100);
        cnt = 0;
        while (sink_en && cnt < 1000) begin cnt++; @(negedge clk); end
        chk(cnt == DC, "R10 discharge hold length", cnt, DC);
        chk(clamp_gnd == 1'b1, "R10 pending power-up begins", int'(clamp_gnd), 1);
        measure_pop(ct, rt, errs);
        chk(vq_ready && ct == CS && rt == RS, "R10 power-up after hold completes", ct + rt, CS + RS);

        // R10 long power-down keeps the sink on, then R8 fixed-delay power-up
        pdn_bit = 1'b1;
        repeat (DC + 30) @(negedge clk);
        chk(sink_en == 1'b1, "R10 sink held while power-down set", int'(sink_en), 1);
        pop_en = 1'b0; pdn_bit = 1'b0;
        @(negedge clk);
        cnt = 0; errs = 0;
        while (!vq_ready && cnt < 1000) begin
            if (ramp_en || !clamp_gnd) errs++;
            cnt++; lrck_tick = rnd_tick(); @(negedge clk);
        end
        lrck_tick = 1'b0;
        chk(cnt == FC, "R8 fixed delay length", cnt, FC);
        chk(errs == 0, "R8 no ramp during fixed delay", errs, 0);

        // R11 reset mid-ramp
        pop_en = 1'b1; pdn_bit = 1'b1; @(negedge clk);
        pdn_bit = 1'b0;
        repeat (DC) @(negedge clk);
        cnt = 0;
        while (!ramp_en && cnt < 2000) begin lrck_tick = 1'b1; cnt++; @(negedge clk); end
        lrck_tick = 1'b0;
        rst_n = 1'b0; @(negedge clk);
        chk(clamp_gnd && !ramp_en && !ctrl_mode && !vq_ready, "R11 reset mid-ramp",
            {clamp_gnd, ramp_en, ctrl_mode}, 3'b100);

        // R4 hardware mode: self power-up, writes and power-down ignored
        do_reset(2'b00);
        pop_en = 1'b1;
        for (int i = 0; i < WB; i++) begin
            lrck_tick = 1'b1; @(negedge clk);
            lrck_tick = 1'b0; @(negedge clk);
        end
        run_until_vq(cnt);
        chk(vq_ready == 1'b1, "R4 hardware mode self power-up", int'(vq_ready), 1);
        wr_stb = 1'b1; pdn_bit = 1'b1; @(negedge clk);
        wr_stb = 1'b0;
        errs = 0;
        repeat (20) begin if (sink_en || !vq_ready) errs++; @(negedge clk); end
        chk(errs == 0 && !ctrl_mode, "R4 power-down and write ignored", errs + int'(ctrl_mode), 0);

        // R12 / R3 random rounds
        for (int r = 0; r < 8; r++) begin
            s = 2'($urandom_range(3, 0));
            do_reset(s);
            pop_en = 1'($urandom_range(1, 0));
            pdn_bit = 1'($urandom_range(1, 0));
            claim = 1'($urandom_range(1, 0));
            cnt = claim ? int'($urandom_range(WB - 1, 0)) : win_len(s);
            for (int i = 0; i < cnt; i++) begin
                lrck_tick = 1'b1; @(negedge clk);
                lrck_tick = 1'b0; @(negedge clk);
            end
            if (claim) begin wr_stb = 1'b1; @(negedge clk); wr_stb = 1'b0; end
            viol = 0; run = 0;
            for (int c = 0; c < 900; c++) begin
                if (int'(clamp_gnd) + int'(ramp_en) + int'(buf_connect) + int'(sink_en) > 1) viol++;
                if (vq_ready != buf_connect) viol++;
                if (sink_en) run++;
                else begin
                    if (run != 0 && run < DC) viol++;
                    run = 0;
                end
                lrck_tick = rnd_tick();
                if ($urandom_range(59, 0) == 0) pdn_bit = ~pdn_bit;
                @(negedge clk);
            end
            lrck_tick = 1'b0;
            chk(viol == 0, "R12 random round output rules", viol, 0);
            chk(ctrl_mode == claim, "R3 random round mode flag", int'(ctrl_mode), int'(claim));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule